// File: doc/BRIEF.md
# Programmable-Gain Amplifier Gain-Control Interface

This block is the digital control front end of a programmable-gain amplifier. It holds a 4-bit gain code and decodes it into a 14-entry one-hot gain select and an amplifier-enable flag. The code arrives in one of two ways, chosen by a mode input, over one shared set of four pins. In parallel mode the four pins carry the code directly, and a hold input can freeze it. In serial mode the pins become chip select (active low), serial data in, serial clock and serial data out. Data is shifted into an 8-bit register, and its low nibble is committed when chip select rises.

All pin inputs are brought into the system clock domain through two-flop synchronizers, and serial clock edges are detected from the synchronized copy. The serial clock must toggle no faster than once every 4 system clocks. Data out always presents the register MSB as it stood at the last serial clock fall, so several devices can share clock and chip select in a daisy chain. A hardware shutdown input freezes the interface and forces the amplifier off. Code 0000 acts as a software power-down.

The control sequencer has five states:
- CTL_OFF: hardware shutdown.
- CTL_IDLE: serial mode, not selected.
- CTL_SEL: selected, shifting.
- CTL_COMMIT: one cycle that loads the gain latch.
- CTL_PAR: parallel mode.

The sequencer moves between them as follows:
- Reset leads to CTL_IDLE.
- From any state, an asserted shutdown leads to CTL_OFF.
- CTL_OFF leads to CTL_PAR or CTL_IDLE when shutdown clears, depending on mode.
- From CTL_IDLE, CTL_SEL or CTL_COMMIT, a high mode leads to CTL_PAR. A mode switch from CTL_SEL abandons the frame.
- CTL_PAR leads to CTL_IDLE when mode goes low.
- CTL_IDLE leads to CTL_SEL on chip select low.
- CTL_SEL leads to CTL_COMMIT on chip select high.
- CTL_COMMIT leads to CTL_IDLE.

Top module: `pga_gain_ctrl`

## Requirements
- R1: With mode high (parallel), the pin code is {d3_in, pin_c2, pin_c1, pin_c0}, with pin_c0 as the least significant bit.
- R2: With mode low and chip select (pin_c0) low, each rising serial clock (pin_c2) shifts pin_c1 into the LSB of an 8-bit register, so the earliest bit ends up as the MSB.
- R3: When chip select rises, the 4 least significant register bits (the last four bits shifted) become the gain code. The upper four bits have no effect on the code.
- R4: Serial clock edges while chip select is high change neither the register nor the code.
- R5: d3_out takes the register MSB on each serial clock fall while selected and keeps that value after chip select rises. d3_oe is 1 in serial mode and 0 in parallel mode.
- R6: In parallel mode with hold low, the code follows the pins. With hold high, the code is frozen and pin changes have no effect.
- R7: gain_sel is one-hot with bit index min(code, 13), so codes 13, 14 and 15 all select bit 13. amp_en is 1 exactly when the code is non-zero and shutdown is low.
- R8: While shutdown is high, amp_en is 0 and serial frames and parallel pin changes are ignored. The code is retained.
- R9: With two devices chained from d3_out to the next device's pin_c1, a 16-bit frame leaves its first 8 bits in the far device. Both devices commit on the single chip select rise.
- R10: After reset the code and register are 0: gain_sel is bit 0, amp_en is 0 and d3_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_par | input | 1 | 1 = parallel code pins, 0 = serial interface |
| hold | input | 1 | Parallel mode: 1 freezes the code |
| shdn | input | 1 | Hardware shutdown |
| pin_c0 | input | 1 | Chip select (active low) / code bit 0 |
| pin_c1 | input | 1 | Serial data in / code bit 1 |
| pin_c2 | input | 1 | Serial clock / code bit 2 |
| d3_in | input | 1 | Input side of the shared fourth pin: code bit 3 |
| d3_out | output | 1 | Serial data out |
| d3_oe | output | 1 | Output enable of the fourth pin (serial mode) |
| gain_sel | output | 14 | One-hot gain select |
| amp_en | output | 1 | Amplifier enable |

## Verification
The bench builds the block with its default parameters: an 8-bit register, a 4-bit code, 14 gain levels and two synchronizer stages. It also builds a second copy, wired as the far device of a daisy chain, which makes the 16-bit frame split observable at both devices' gain outputs. With the 4-bit code, the parallel sweep covers all sixteen codes, including the three that saturate at the top gain. Serial clock half-periods of six system clocks keep the chained data path within the sampling margin of the two-stage synchronizers.

// File: rtl/pga_gain_pkg.sv
package pga_gain_pkg;
    localparam int SR_W     = 8;
    localparam int CODE_W   = 4;
    localparam int N_LEVELS = 14;

    typedef enum logic [2:0] {
        CTL_OFF,
        CTL_IDLE,
        CTL_SEL,
        CTL_COMMIT,
        CTL_PAR
    } ctl_state_e;
endpackage

// File: rtl/pga_sync.sv
module pga_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pga_ctl_fsm.sv
module pga_ctl_fsm
    import pga_gain_pkg::*;
#(
    parameter int SRW = SR_W,
    parameter int CW  = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_par,
    input  logic          hold,
    input  logic          shdn,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          sdi,
    input  logic [CW-1:0] par_code,
    output logic [CW-1:0] code,
    output logic          sdo
);
    ctl_state_e st, st_nxt;
    logic           sck_q;
    logic [SRW-1:0] sr_q;
    logic [CW-1:0]  code_q;
    logic           sdo_q;
    logic           sck_rise, sck_fall;

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CTL_IDLE;
        else        st <= st_nxt;
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            CTL_OFF:    if (!shdn) st_nxt = mode_par ? CTL_PAR : CTL_IDLE;
            CTL_IDLE:   if (shdn) st_nxt = CTL_OFF;
                        else if (mode_par) st_nxt = CTL_PAR;
                        else if (!cs_n) st_nxt = CTL_SEL;
            CTL_SEL:    if (shdn) st_nxt = CTL_OFF;
                        else if (mode_par) st_nxt = CTL_PAR;
                        else if (cs_n) st_nxt = CTL_COMMIT;
            CTL_COMMIT: if (shdn) st_nxt = CTL_OFF;
                        else if (mode_par) st_nxt = CTL_PAR;
                        else st_nxt = CTL_IDLE;
            CTL_PAR:    if (shdn) st_nxt = CTL_OFF;
                        else if (!mode_par) st_nxt = CTL_IDLE;
            default:    st_nxt = CTL_IDLE;
        endcase
    end

    // datapath / outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            sr_q   <= '0;
            code_q <= '0;
            sdo_q  <= 1'b0;
        end else begin
            sck_q <= sck;
            if (st == CTL_SEL && sck_rise) sr_q  <= {sr_q[SRW-2:0], sdi};
            if (st == CTL_SEL && sck_fall) sdo_q <= sr_q[SRW-1];
            if (st == CTL_COMMIT)          code_q <= sr_q[CW-1:0];
            if (st == CTL_PAR && !hold)    code_q <= par_code;
        end
    end

    assign code = code_q;
    assign sdo  = sdo_q;

    a_r4_sr_frozen_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CTL_SEL) |=> $stable(sr_q));
    a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CTL_PAR && hold) |=> $stable(code_q));
    a_r8_off_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CTL_OFF) |=> ($stable(code_q) && $stable(sr_q)));
    a_r3_code_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> ($past(st) == CTL_COMMIT || $past(st) == CTL_PAR));
    a_r5_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_q) |-> $past(st == CTL_SEL && sck_fall));
endmodule

// File: rtl/pga_gain_decode.sv
module pga_gain_decode
    import pga_gain_pkg::*;
#(
    parameter int CW  = CODE_W,
    parameter int NLV = N_LEVELS
) (
    input  logic [CW-1:0]  code,
    input  logic           shdn,
    output logic [NLV-1:0] gain_sel,
    output logic           amp_en
);
    localparam logic [CW-1:0] TOP_IDX = CW'(NLV - 1);

    logic [CW-1:0] idx;
    assign idx = (code > TOP_IDX) ? TOP_IDX : code;

    for (genvar i = 0; i < NLV; i++) begin : g_sel
        assign gain_sel[i] = (idx == CW'(i));
    end

    assign amp_en = (code != '0) && !shdn;
endmodule

// File: rtl/pga_gain_ctrl.sv
module pga_gain_ctrl
    import pga_gain_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_par,
    input  logic                hold,
    input  logic                shdn,
    input  logic                pin_c0,
    input  logic                pin_c1,
    input  logic                pin_c2,
    input  logic                d3_in,
    output logic                d3_out,
    output logic                d3_oe,
    output logic [N_LEVELS-1:0] gain_sel,
    output logic                amp_en
);
    localparam int NSYNC = 7;

    logic [NSYNC-1:0] raw, syn;
    logic [CODE_W-1:0] code;
    logic c0_s, c1_s, c2_s, d3_s, mode_s, hold_s, shdn_s;

    assign raw = {shdn, hold, mode_par, d3_in, pin_c2, pin_c1, pin_c0};
    assign {shdn_s, hold_s, mode_s, d3_s, c2_s, c1_s, c0_s} = syn;

    pga_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST(7'b000_0001)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    pga_ctl_fsm #(.SRW(SR_W), .CW(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_par(mode_s), .hold(hold_s), .shdn(shdn_s),
        .cs_n(c0_s), .sck(c2_s), .sdi(c1_s), .par_code({d3_s, c2_s, c1_s, c0_s}),
        .code(code), .sdo(d3_out)
    );

    pga_gain_decode #(.CW(CODE_W), .NLV(N_LEVELS)) u_dec (
        .code(code), .shdn(shdn_s), .gain_sel(gain_sel), .amp_en(amp_en)
    );

    assign d3_oe = ~mode_s;

    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gain_sel) == 1);
    a_r8_no_enable_in_shdn: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shdn_s) && shdn_s |-> !amp_en);
endmodule

// File: tb/tb_pga_gain_ctrl.sv
`timescale 1ns/1ps
module tb_pga_gain_ctrl;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_par = 1'b0, hold = 1'b0, shdn = 1'b0;
    logic p0 = 1'b1, p1 = 1'b0, p2 = 1'b0, p3 = 1'b0;
    logic d3_out, d3_oe, amp_en;
    logic [13:0] gain_sel;
    logic f_out, f_oe, f_en;
    logic [13:0] f_sel;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [7:0] m_sr = 8'h00;
    logic [3:0] m_code = 4'h0;
    logic m_dout = 1'b0;

    always #2 clk = ~clk;

    pga_gain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .hold(hold), .shdn(shdn),
        .pin_c0(p0), .pin_c1(p1), .pin_c2(p2), .d3_in(p3),
        .d3_out(d3_out), .d3_oe(d3_oe), .gain_sel(gain_sel), .amp_en(amp_en)
    );

    pga_gain_ctrl dut_far (
        .clk(clk), .rst_n(rst_n), .mode_par(1'b0), .hold(1'b0), .shdn(1'b0),
        .pin_c0(p0), .pin_c1(d3_out), .pin_c2(p2), .d3_in(1'b0),
        .d3_out(f_out), .d3_oe(f_oe), .gain_sel(f_sel), .amp_en(f_en)
    );

    function automatic logic [13:0] exp_sel(input logic [3:0] c);
        return 14'd1 << ((c > 4'd13) ? 4'd13 : c);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_gain(input string req);
        chk(req, {18'd0, gain_sel}, {18'd0, exp_sel(m_code)});
        chk(req, {31'd0, amp_en}, {31'd0, (m_code != 4'd0) && !shdn});
    endtask

    // serial frame, n bits from bits[n-1] down to bits[0]; live = device responds
    task automatic frame(input logic [15:0] bits, input int n, input bit live);
        p0 = 1'b0; tick(HP);
        for (int i = n - 1; i >= 0; i--) begin
            p1 = bits[i]; tick(HP);
            p2 = 1'b1; tick(HP);
            p2 = 1'b0; tick(HP);
            if (live) begin m_sr = {m_sr[6:0], bits[i]}; m_dout = m_sr[7]; end
        end
        p0 = 1'b1; tick(3 * HP);
        if (live) m_code = m_sr[3:0];
    endtask

    task automatic go_par();
        mode_par = 1'b1; tick(HP);
    endtask

    task automatic go_ser();
        p0 = 1'b1; p2 = 1'b0; tick(HP);
        mode_par = 1'b0; tick(HP);
    endtask

    task automatic set_pins(input logic [3:0] c);
        {p3, p2, p1, p0} = c; tick(HP);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'd20240601);
        tick(3); rst_n = 1'b1; tick(4);
        // R10 reset state
        check_gain("R10");
        chk("R10 dout", {31'd0, d3_out}, 0);
        chk("R5 oe serial", {31'd0, d3_oe}, 1);

        // R2 R3 serial byte
        frame(16'h00A5, 8, 1'b1);
        check_gain("R2/R3 A5");
        chk("R5 dout", {31'd0, d3_out}, {31'd0, m_dout});
        frame(16'h00F3, 8, 1'b1);
        check_gain("R3 upper ignored");

        // R4 clocks with cs high
        p1 = 1'b1;
        for (int k = 0; k < 5; k++) begin p2 = 1'b1; tick(HP); p2 = 1'b0; tick(HP); end
        check_gain("R4 code");
        frame(16'h0, 0, 1'b1);
        check_gain("R4 register unchanged");
        chk("R5 dout held", {31'd0, d3_out}, {31'd0, m_dout});

        // R1 R7 parallel sweep
        go_par();
        chk("R5 oe parallel", {31'd0, d3_oe}, 0);
        chk("R5 dout retained", {31'd0, d3_out}, {31'd0, m_dout});
        for (int c = 0; c < 16; c++) begin
            set_pins(4'(c)); m_code = 4'(c);
            check_gain("R1/R7 sweep");
        end

        // R6 hold
        set_pins(4'd7); m_code = 4'd7;
        hold = 1'b1; tick(HP);
        set_pins(4'd2);
        check_gain("R6 hold freeze");
        hold = 1'b0; tick(HP); m_code = 4'd2;
        check_gain("R6 passthrough");

        // R8 shutdown
        set_pins(4'd9); m_code = 4'd9;
        shdn = 1'b1; tick(HP);
        set_pins(4'd4);
        check_gain("R8 parallel ignored");
        go_ser();
        frame(16'h0066, 8, 1'b0);
        check_gain("R8 serial ignored");
        shdn = 1'b0; tick(HP);
        frame(16'h0, 0, 1'b1);
        check_gain("R8 register retained");

        // R9 daisy chain
        frame(16'h5C3A, 16, 1'b1);
        check_gain("R9 near");
        chk("R9 far", {18'd0, f_sel}, {18'd0, exp_sel(4'hC)});

        // random mix
        for (int it = 0; it < 24; it++) begin
            r = $urandom;
            if (r[0]) begin
                if (!mode_par) go_par();
                set_pins(r[7:4]); m_code = r[7:4];
                check_gain("R1/R7 random");
            end else begin
                if (mode_par) go_ser();
                frame({8'd0, r[15:8]}, 8, 1'b1);
                check_gain("R2/R3 random");
                chk("R5 random dout", {31'd0, d3_out}, {31'd0, m_dout});
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule